// File: doc/BRIEF.md
# Packet-Driven I2C Master Transfer Sequencer

This block turns command packets into byte-level bus operations for an I2C bit engine. Software loads a transmit queue of 32-bit words: three header words per transfer, then the write payload packed four bytes to a word. The sequencer reads the headers, issues START and the address byte, and then either streams payload bytes out or collects received bytes into words for a receive queue. Each transfer ends with a STOP, or with a repeated START when the header asks to keep the bus for a following read packet.

Transfer outcome is reported through three sticky flags that are cleared by writing ones. A second status output shows how many transmit entries are free and how many receive entries hold data. A missing acknowledge or a lost arbitration aborts the transfer, empties both queues and returns the sequencer to waiting for a new header.

The bit engine is reached through a command channel with a valid/ready handshake and a response strobe that carries the received byte, a NACK indication and an arbitration-lost indication. Exactly one command is outstanding at a time.

Top module: `i2c_pkt_seq`

## Requirements
- R1: A transfer consumes three header words in order. The first is ignored. Bits 11:0 of the second give the byte count minus one, and its upper bits are ignored. In the third, bits 7:0 are the address byte, bit 19 selects read and bit 16 selects a repeated-START ending. The first command is START (op 0), and the address byte follows unchanged as op 1.
- R2: A write sends exactly count bytes with op 2, taken little-endian from the payload words (byte 0 in bits 7:0). Only the low count mod 4 bytes of a final partial word are sent.
- R3: A read issues op 3 (read, then ACK) for every byte but the last and op 4 (read, then NACK) for the last. Bytes are packed little-endian into receive words, and a final partial word has zero upper bytes.
- R4: A transfer without error ends with op 5 (STOP), or with op 6 (repeated START) and no STOP when bit 16 was set, and then sets the done flag.
- R5: A NACK response to the address or to a write byte stops further payload. The sequencer issues STOP and sets the NACK flag, and not the done flag.
- R6: An arbitration-lost response to any command of a transfer issues no further command and sets the arbitration flag.
- R7: On either abort, both queues are emptied: transmit free count returns to the depth and receive fill count to zero.
- R8: The flags are done (bit 0), NACK (bit 1) and arbitration lost (bit 2). Writing a mask clears exactly the flags whose mask bits are 1; others keep their value.
- R9: The transmit free count equals depth minus occupancy, and the receive fill count equals occupancy. A push to a full transmit queue and a pop from an empty receive queue are ignored.
- R10: A command is held with stable op and byte while valid and not ready. The next command is issued only after the response to the previous one.
- R11: After reset, all flags are zero, the transmit free count is the depth, the receive fill count is zero and no command is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Push one word into the transmit queue |
| tx_wdata | input | 32 | Word to push |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 32 | Head of the receive queue |
| tx_free | output | 4 | Free transmit entries |
| rx_fill | output | 4 | Filled receive entries |
| sts_clr | input | 1 | Write strobe for flag clearing |
| sts_clr_mask | input | 3 | Flags to clear (1 clears) |
| sts_flags | output | 3 | Done, NACK, arbitration lost |
| cmd_valid | output | 1 | Command to the bit engine is valid |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_op | output | 3 | Command code 0..6 |
| cmd_byte | output | 8 | Address or data byte for ops 1 and 2 |
| rsp_valid | input | 1 | Response strobe from the bit engine |
| rsp_byte | input | 8 | Received byte for read ops |
| rsp_nack | input | 1 | Target did not acknowledge |
| rsp_arb | input | 1 | Arbitration was lost |

## Verification
A wrong byte index or lane shows at the bit-engine port as a misordered or extra data command within the same transfer, and in the receive words right after the transfer ends. A wrong end condition shows in the final command code and in the flags the cycle after the last response. A corrupted abort path leaves non-zero queue counts or a wrong flag, visible the cycle after the failing response and checked before the next header is pushed.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_ADDR    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_RD_ACK  = 3'd3,
    OP_RD_NACK = 3'd4,
    OP_STOP    = 3'd5,
    OP_RSTART  = 3'd6
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR2, S_HDR3, S_CMD, S_RSP, S_WFETCH, S_RPUSH
  } seq_state_e;

  localparam int LEN_LSB   = 0;
  localparam int ADDR_LSB  = 0;
  localparam int RD_BIT    = 19;
  localparam int RS_BIT    = 16;

  localparam int FLAG_W    = 3;
  localparam int FLAG_DONE = 0;
  localparam int FLAG_NACK = 1;
  localparam int FLAG_ARB  = 2;
endpackage

// File: rtl/i2cps_fifo.sv
module i2cps_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, wptr_n, rptr, rptr_n;
  logic [CW-1:0]    level_n;
  logic             full, empty, do_push, do_pop;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    level_n = level;
    if (flush) begin
      wptr_n  = '0;
      rptr_n  = '0;
      level_n = '0;
    end else begin
      if (do_push) wptr_n = bump(wptr);
      if (do_pop)  rptr_n = bump(rptr);
      level_n = level + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      level <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  // R9
  lvl_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !flush) |=> (level == $past(level) + 1'b1));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)));
endmodule

// File: rtl/i2cps_status.sv
module i2cps_status #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_mask,
  output logic [FW-1:0] flags
);
  logic [FW-1:0] flags_n, clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_comb begin
    flags_n = (flags & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;
  end

  // R8
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set_vec == '0) |=> ((flags & $past(clr_mask)) == '0));

  // R8
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set_vec == '0) |=> ((flags & ~$past(clr_mask)) == ($past(flags) & ~$past(clr_mask))));

  // R8
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/i2cps_seq.sv
module i2cps_seq
  import i2cps_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_dout,
  input  logic              tx_empty,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_din,
  output logic              flush,
  output logic [FLAG_W-1:0] set_vec,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  input  logic              rsp_nack,
  input  logic              rsp_arb
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  seq_state_e        state, state_n;
  bus_op_e           op_r, op_n;
  logic [7:0]        byte_r, byte_n;
  logic [7:0]        addr_r, addr_n;
  logic              rd_r, rd_n, rs_r, rs_n, abort_r, abort_n;
  logic [LEN_W-1:0]  len_r, len_n, idx_r, idx_n;
  logic [DATA_W-1:0] wword_r, wword_n, rword_r, rword_n;

  logic              last, nxt_last, lane_end;
  logic [LANE_W-1:0] lane;
  bus_op_e           end_op;

  assign lane     = idx_r[LANE_W-1:0];
  assign lane_end = (lane == LANE_W'(LANES - 1));
  assign last     = (idx_r == len_r);
  assign nxt_last = ((idx_r + 1'b1) == len_r);
  assign end_op   = rs_r ? OP_RSTART : OP_STOP;

  assign cmd_valid = (state == S_CMD);
  assign cmd_op    = op_r;
  assign cmd_byte  = byte_r;
  assign rx_din    = rword_r;

  always_comb begin
    state_n = state;
    op_n    = op_r;
    byte_n  = byte_r;
    addr_n  = addr_r;
    rd_n    = rd_r;
    rs_n    = rs_r;
    abort_n = abort_r;
    len_n   = len_r;
    idx_n   = idx_r;
    wword_n = wword_r;
    rword_n = rword_r;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    flush   = 1'b0;
    set_vec = '0;
    unique case (state)
      S_IDLE: if (!tx_empty) begin
        tx_pop  = 1'b1;
        state_n = S_HDR2;
      end
      S_HDR2: if (!tx_empty) begin
        tx_pop  = 1'b1;
        len_n   = tx_dout[LEN_LSB +: LEN_W];
        state_n = S_HDR3;
      end
      S_HDR3: if (!tx_empty) begin
        tx_pop  = 1'b1;
        addr_n  = tx_dout[ADDR_LSB +: 8];
        rd_n    = tx_dout[RD_BIT];
        rs_n    = tx_dout[RS_BIT];
        idx_n   = '0;
        abort_n = 1'b0;
        rword_n = '0;
        op_n    = OP_START;
        state_n = S_CMD;
      end
      S_CMD: if (cmd_ready) state_n = S_RSP;
      S_RSP: if (rsp_valid) begin
        if (rsp_arb && !abort_r) begin
          flush             = 1'b1;
          set_vec[FLAG_ARB] = 1'b1;
          state_n           = S_IDLE;
        end else begin
          unique case (op_r)
            OP_START: begin
              op_n    = OP_ADDR;
              byte_n  = addr_r;
              state_n = S_CMD;
            end
            OP_ADDR, OP_WRITE: begin
              if (rsp_nack) begin
                abort_n = 1'b1;
                op_n    = OP_STOP;
                state_n = S_CMD;
              end else if (op_r == OP_ADDR && rd_r) begin
                op_n    = last ? OP_RD_NACK : OP_RD_ACK;
                state_n = S_CMD;
              end else if (op_r == OP_ADDR) begin
                state_n = S_WFETCH;
              end else if (last) begin
                op_n    = end_op;
                state_n = S_CMD;
              end else begin
                idx_n = idx_r + 1'b1;
                if (lane_end) begin
                  state_n = S_WFETCH;
                end else begin
                  byte_n  = 8'(wword_r >> (8 * (int'(lane) + 1)));
                  state_n = S_CMD;
                end
              end
            end
            OP_RD_ACK, OP_RD_NACK: begin
              rword_n = rword_r | (DATA_W'(rsp_byte) << (8 * int'(lane)));
              if (lane_end || last) begin
                state_n = S_RPUSH;
              end else begin
                idx_n   = idx_r + 1'b1;
                op_n    = nxt_last ? OP_RD_NACK : OP_RD_ACK;
                state_n = S_CMD;
              end
            end
            default: begin
              if (abort_r) begin
                flush              = 1'b1;
                set_vec[FLAG_NACK] = 1'b1;
              end else begin
                set_vec[FLAG_DONE] = 1'b1;
              end
              state_n = S_IDLE;
            end
          endcase
        end
      end
      S_WFETCH: if (!tx_empty) begin
        tx_pop  = 1'b1;
        wword_n = tx_dout;
        byte_n  = tx_dout[7:0];
        op_n    = OP_WRITE;
        state_n = S_CMD;
      end
      S_RPUSH: if (!rx_full) begin
        rx_push = 1'b1;
        rword_n = '0;
        if (last) begin
          op_n = end_op;
        end else begin
          idx_n = idx_r + 1'b1;
          op_n  = nxt_last ? OP_RD_NACK : OP_RD_ACK;
        end
        state_n = S_CMD;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_r    <= OP_START;
      byte_r  <= '0;
      addr_r  <= '0;
      rd_r    <= 1'b0;
      rs_r    <= 1'b0;
      abort_r <= 1'b0;
      len_r   <= '0;
      idx_r   <= '0;
      wword_r <= '0;
      rword_r <= '0;
    end else begin
      state   <= state_n;
      op_r    <= op_n;
      byte_r  <= byte_n;
      addr_r  <= addr_n;
      rd_r    <= rd_n;
      rs_r    <= rs_n;
      abort_r <= abort_n;
      len_r   <= len_n;
      idx_r   <= idx_n;
      wword_r <= wword_n;
      rword_r <= rword_n;
    end
  end

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // R10
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R6
  arb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RSP && rsp_valid && rsp_arb && !abort_r) |=> (state == S_IDLE && !cmd_valid));

  // R8
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set_vec));

  // R9
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty);

  // R3
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full);
endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
  import i2cps_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 12,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [CNT_W-1:0]  tx_free,
  output logic [CNT_W-1:0]  rx_fill,
  input  logic              sts_clr,
  input  logic [FLAG_W-1:0] sts_clr_mask,
  output logic [FLAG_W-1:0] sts_flags,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  input  logic              rsp_nack,
  input  logic              rsp_arb
);
  logic [DATA_W-1:0] tx_dout, rx_din;
  logic [CNT_W-1:0]  tx_lvl, rx_lvl;
  logic              tx_pop, rx_push, flush;
  logic [FLAG_W-1:0] set_vec;

  assign tx_free = CNT_W'(FIFO_DEPTH) - tx_lvl;
  assign rx_fill = rx_lvl;

  i2cps_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_wr), .din(tx_wdata), .pop(tx_pop),
    .dout(tx_dout), .level(tx_lvl)
  );

  i2cps_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .din(rx_din), .pop(rx_rd),
    .dout(rx_rdata), .level(rx_lvl)
  );

  i2cps_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tx_dout(tx_dout), .tx_empty(tx_lvl == '0), .tx_pop(tx_pop),
    .rx_full(rx_lvl == CNT_W'(FIFO_DEPTH)), .rx_push(rx_push), .rx_din(rx_din),
    .flush(flush), .set_vec(set_vec),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb)
  );

  i2cps_status #(.FW(FLAG_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(sts_clr), .clr_mask(sts_clr_mask), .flags(sts_flags)
  );

  // R7
  abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_lvl == '0 && rx_lvl == '0));
endmodule

// File: tb/i2c_pkt_seq_test.sv
`timescale 1ns/1ps
module i2c_pkt_seq_test;
  logic        clk, rst_n;
  logic        tx_wr, rx_rd, sts_clr;
  logic [31:0] tx_wdata, rx_rdata;
  logic [3:0]  tx_free, rx_fill;
  logic [2:0]  sts_clr_mask, sts_flags, cmd_op;
  logic        cmd_valid, cmd_ready, rsp_valid, rsp_nack, rsp_arb;
  logic [7:0]  cmd_byte, rsp_byte;

  i2c_pkt_seq uut (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_free(tx_free), .rx_fill(rx_fill),
    .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .sts_flags(sts_flags),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  // bit-engine model state
  bit         model_hold;
  int         nack_at, arb_at, cmd_idx, rd_cnt;
  logic [7:0] addr_seen;
  logic [7:0] wr_log[$];
  int         op_log[$];
  int         rd_ops[$];
  logic [7:0] rd_src [64];
  logic [7:0] wsrc [64];
  int         m_op;
  logic [7:0] m_b;

  // current transfer
  bit         cur_rd, cur_rs, keep_flags;
  int         cur_len;
  logic [7:0] cur_addr;

  task automatic check(string req, longint act, longint exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_word(bit from_rd, int w, int len);
    logic [31:0] v = '0;
    for (int j = 0; j < 4; j++) begin
      int k = 4 * w + j;
      if (k < len) v[8*j +: 8] = from_rd ? rd_src[k] : wsrc[k];
    end
    return v;
  endfunction

  initial begin
    cmd_ready = 0; rsp_valid = 0; rsp_byte = 0; rsp_nack = 0; rsp_arb = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_nack = 0; rsp_arb = 0;
      if (rst_n && cmd_valid && !model_hold && ($urandom_range(2, 0) != 0)) begin
        m_op = int'(cmd_op);
        m_b  = cmd_byte;
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        repeat ($urandom_range(2, 0)) @(negedge clk);
        rsp_arb = (cmd_idx == arb_at);
        cmd_idx++;
        op_log.push_back(m_op);
        case (m_op)
          1: begin addr_seen = m_b; rsp_nack = (nack_at == 0); end
          2: begin wr_log.push_back(m_b); rsp_nack = (nack_at == wr_log.size()); end
          3, 4: begin
            rd_ops.push_back(m_op);
            rsp_byte = (rd_cnt < 64) ? rd_src[rd_cnt] : 8'h00;
            rd_cnt++;
          end
          default: ;
        endcase
        rsp_valid = 1;
      end
    end
  end

  task automatic push_word(logic [31:0] w);
    while (tx_free == 0) @(negedge clk);
    tx_wr = 1; tx_wdata = w;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic start_xfer(bit rd, bit rs, int len, int nk, int ab);
    logic [6:0] dev = 7'($urandom);
    cur_rd = rd; cur_rs = rs; cur_len = len;
    cur_addr = {dev, rd};
    for (int i = 0; i < 64; i++) begin
      wsrc[i] = 8'($urandom);
      rd_src[i] = 8'($urandom);
    end
    nack_at = nk; arb_at = ab; cmd_idx = 0; rd_cnt = 0;
    wr_log.delete(); op_log.delete(); rd_ops.delete();
    addr_seen = 8'hxx;
    push_word($urandom);                                             // R1 ignored word
    push_word(($urandom & 32'hFFFF_F000) | 32'(len - 1));            // R1
    push_word((32'(rd) << 19) | (32'(rs) << 16) | 32'(cur_addr));    // R1
  endtask

  task automatic push_payload();
    if (!cur_rd)
      for (int w = 0; w < (cur_len + 3) / 4; w++) push_word(pack_word(0, w, cur_len));
  endtask

  task automatic finish_xfer();
    int t = 0;
    int words = (cur_len + 3) / 4;
    bit err = (nack_at >= 0) || (arb_at >= 0);
    logic [2:0] exp_f = (nack_at >= 0) ? 3'b010 : (arb_at >= 0) ? 3'b100 : 3'b001;
    while (sts_flags == 0 && t < 4000) begin @(negedge clk); t++; end
    @(negedge clk);
    check("R4", t < 4000, 1, "transfer finished");
    check(nack_at >= 0 ? "R5" : arb_at >= 0 ? "R6" : "R4", sts_flags, exp_f, "flags");
    if (arb_at < 0 || arb_at >= 1) begin
      check("R1", op_log.size() > 0 ? op_log[0] : -1, 0, "first op START");
    end
    if (arb_at < 0 || arb_at >= 2) check("R1", addr_seen, cur_addr, "address byte");
    if (arb_at >= 0) begin
      check("R6", op_log.size(), arb_at + 1, "commands after arb lost");
    end else if (nack_at >= 0) begin
      check("R5", wr_log.size(), nack_at, "bytes before NACK");
      check("R5", op_log[op_log.size() - 1], 5, "STOP after NACK");
    end else begin
      check("R4", op_log[op_log.size() - 1], cur_rs ? 6 : 5, "end op");
      if (!cur_rd) begin
        check("R2", wr_log.size(), cur_len, "write byte count");
        for (int i = 0; i < wr_log.size() && i < cur_len; i++)
          check("R2", wr_log[i], wsrc[i], $sformatf("write byte %0d", i));
      end else begin
        check("R3", rd_ops.size(), cur_len, "read op count");
        for (int i = 0; i < rd_ops.size(); i++)
          check("R3", rd_ops[i], (i == cur_len - 1) ? 4 : 3, $sformatf("read op %0d", i));
        check("R3", rx_fill, words, "rx words");
        for (int w = 0; w < words; w++) begin
          check("R3", rx_rdata, pack_word(1, w, cur_len), $sformatf("rx word %0d", w));
          rx_rd = 1; @(negedge clk); rx_rd = 0;
        end
      end
    end
    if (err) begin
      check("R7", tx_free, 8, "tx free after abort");
      check("R7", rx_fill, 0, "rx fill after abort");
    end else begin
      check("R9", tx_free, 8, "tx free at end");
      check("R9", rx_fill, 0, "rx fill after drain");
    end
    if (!keep_flags) begin
      sts_clr = 1; sts_clr_mask = sts_flags;
      @(negedge clk);
      sts_clr = 0;
      check("R8", sts_flags, 0, "flags after clear");
    end
  endtask

  task automatic run_xfer(bit rd, bit rs, int len, int nk, int ab);
    start_xfer(rd, rs, len, nk, ab);
    push_payload();
    finish_xfer();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tx_wr = 0; tx_wdata = 0; rx_rd = 0; sts_clr = 0; sts_clr_mask = 0;
    model_hold = 0; keep_flags = 0; nack_at = -1; arb_at = -1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    check("R11", sts_flags, 0, "flags after reset");
    check("R11", tx_free, 8, "tx free after reset");
    check("R11", rx_fill, 0, "rx fill after reset");
    check("R11", cmd_valid, 0, "cmd valid after reset");

    // directed corners
    run_xfer(0, 0, 1, -1, -1);    // R2 single byte
    run_xfer(0, 0, 4, -1, -1);    // R2 full word
    run_xfer(0, 1, 5, -1, -1);    // R2 partial word, R4 repeated start
    run_xfer(0, 0, 40, -1, -1);   // R2 payload larger than queue

    rx_rd = 1; @(negedge clk); rx_rd = 0;   // R9 pop on empty
    check("R9", rx_fill, 0, "pop on empty ignored");
    run_xfer(1, 0, 1, -1, -1);    // R3 single read
    run_xfer(1, 0, 3, -1, -1);    // R3 partial word zero fill
    run_xfer(1, 0, 32, -1, -1);   // R3 queue exactly full

    run_xfer(0, 0, 12, 0, -1);    // R5 NACK on address, R7 unread payload flushed
    run_xfer(0, 0, 7, 7, -1);     // R5 NACK on last byte
    run_xfer(1, 0, 9, 0, -1);     // R5 NACK on read address
    run_xfer(1, 0, 10, -1, 0);    // R6 arb lost at START
    run_xfer(1, 0, 10, -1, 8);    // R6 arb lost mid read, R7 rx flushed

    // R9 push to a full transmit queue is ignored
    model_hold = 1;
    start_xfer(0, 0, 32, -1, -1);
    for (int i = 0; i < 200 && tx_free != 8; i++) @(negedge clk);
    push_payload();
    check("R9", tx_free, 0, "tx full");
    tx_wr = 1; tx_wdata = 32'hDEAD_BEEF; @(negedge clk); tx_wr = 0;
    check("R9", tx_free, 0, "push on full ignored");
    model_hold = 0;
    finish_xfer();

    // R8 partial clear keeps other flags
    keep_flags = 1;
    run_xfer(0, 0, 2, -1, -1);
    keep_flags = 0;
    sts_clr = 1; sts_clr_mask = 3'b110; @(negedge clk); sts_clr = 0;
    check("R8", sts_flags, 3'b001, "partial clear");
    sts_clr = 1; sts_clr_mask = 3'b001; @(negedge clk); sts_clr = 0;
    check("R8", sts_flags, 3'b000, "done cleared");

    // constrained random
    for (int n = 0; n < 30; n++) begin
      bit rd = 1'($urandom);
      bit rs = 1'($urandom);
      int len = $urandom_range(20, 1);
      int sel = $urandom_range(5, 0);
      int nk = -1, ab = -1;
      if (sel == 0) nk = rd ? 0 : $urandom_range(len, 0);
      else if (sel == 1) ab = $urandom_range(len + 2, 0);
      run_xfer(rd, rs, len, nk, ab);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule